// File: doc/BRIEF.md
# Program Address Sequencer with One-Deep Return Stack

This block produces the 10-bit fetch address for a small accumulator controller with a 1024-word program store. In each instruction cycle where the step strobe is high, it picks the next address from one of six sources: the incremented counter, the jump or call target, the saved return address, a low-byte write that keeps the current 256-word region, a taken conditional skip, or reset. The decoder outside the block drives one control strobe per instruction. The block does not decode instructions.

Every change of control flow discards the word that was fetched in the same cycle. The block raises a flush flag for exactly one instruction cycle so that the decoder treats that slot as a no-op. Any strobes that arrive with the flushed slot are ignored. The return stack holds one address. A second call before a return overwrites the first saved address. The stack has no software access, and its contents are undefined until the first call.

Top module: `pcseq_top`

## Requirements
- R1: On a step with no flush and no active strobe, the fetch address advances by one and wraps from 1023 to 0. The flush flag stays low.
- R2: While rst_ni is low, the fetch address is 0 and the flush flag is low.
- R3: A step with skip_i high and cond_i high sets the address to the current fetch address plus 1 and raises the flush flag. The fetch address already points one past the skip instruction, so execution resumes at the skip instruction plus 2. With cond_i low, the step behaves as a plain increment.
- R4: A step with low_wr_i high loads {fetch_address[9:8], low_data_i[7:0]} and raises the flush flag.
- R5: A step with jump_i high loads all 10 bits of target_i and raises the flush flag.
- R6: A step with call_i high loads target_i, saves the current fetch address as the return address, and raises the flush flag.
- R7: A step with ret_i high loads the saved return address and raises the flush flag.
- R8: A second call before a return overwrites the saved address, so the next return goes to the address saved by the most recent call.
- R9: The flush flag stays high for exactly one step. On that step all strobes are ignored and the address advances by one.
- R10: When several strobes are high on the same step, one strobe wins in this order: call, then jump, then return, then low-byte write, then skip.
- R11: While step_i is low, the fetch address, the flush flag and the saved address do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance one instruction cycle |
| call_i | input | 1 | Call strobe |
| jump_i | input | 1 | Jump strobe |
| ret_i | input | 1 | Return strobe |
| low_wr_i | input | 1 | Write to the low address byte |
| low_data_i | input | 8 | Data for a low-byte write |
| skip_i | input | 1 | Conditional skip instruction |
| cond_i | input | 1 | Skip condition is true |
| target_i | input | 10 | Target address field of a jump or call |
| fetch_addr_o | output | 10 | Next fetch address |
| flush_o | output | 1 | Current slot is a dummy cycle |

## Verification
The hardest case to reach from the ports is a flushed slot that arrives together with strobes, where a call or a return must not take effect. Two other hard cases are a nested call followed by a return, and a low-byte write while the counter sits in an upper region. Directed sequences set each of these up on purpose: a jump into region 2 or 3, strobes held high during the flush step, and two calls in a row before a return. A long random run with sparse strobes and idle steps then mixes these cases with wrap-around at address 1023. The bench issues a return only after at least one call, because the saved address is undefined before that.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    SRC_INC,
    SRC_SKIP,
    SRC_LOW,
    SRC_TGT,
    SRC_RET
  } src_e;
endpackage

// File: rtl/pcseq_src_sel.sv
module pcseq_src_sel
  import pcseq_pkg::*;
(
  input  logic flush_i,
  input  logic call_i,
  input  logic jump_i,
  input  logic ret_i,
  input  logic low_wr_i,
  input  logic skip_i,
  input  logic cond_i,
  output src_e src_o,
  output logic push_o,
  output logic redirect_o
);
  // fixed priority: call > jump > ret > low write > skip
  always_comb begin
    src_o  = SRC_INC;
    push_o = 1'b0;
    if (!flush_i) begin
      if (call_i) begin
        src_o  = SRC_TGT;
        push_o = 1'b1;
      end else if (jump_i)           src_o = SRC_TGT;
      else if (ret_i)                src_o = SRC_RET;
      else if (low_wr_i)             src_o = SRC_LOW;
      else if (skip_i && cond_i)     src_o = SRC_SKIP;
    end
  end

  assign redirect_o = (src_o != SRC_INC);

  // R9
  always_comb flush_ignore_chk: assert (!(flush_i && (push_o || redirect_o)));
endmodule

// File: rtl/pcseq_addr_mux.sv
module pcseq_addr_mux
  import pcseq_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned LW = 8
) (
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] stack_i,
  input  logic [AW-1:0] target_i,
  input  logic [LW-1:0] low_i,
  input  src_e          src_i,
  output logic [AW-1:0] pc_o
);
  localparam int unsigned HW = AW - LW;

  logic [AW-1:0] inc;
  logic [AW-1:0] low_tgt;

  assign inc = pc_i + AW'(1);

  generate
    if (HW > 0) begin : g_region
      assign low_tgt = {pc_i[AW-1:LW], low_i};
    end else begin : g_flat
      assign low_tgt = low_i[AW-1:0];
    end
  endgenerate

  always_comb begin
    unique case (src_i)
      SRC_TGT: pc_o = target_i;
      SRC_RET: pc_o = stack_i;
      SRC_LOW: pc_o = low_tgt;
      default: pc_o = inc;  // skip uses the same +1: fetch addr already past skip
    endcase
  end
endmodule

// File: rtl/pcseq_ret_stack.sv
module pcseq_ret_stack #(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] data_o
);
  logic [AW-1:0] entry_q;

  // single entry: a push always overwrites
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     entry_q <= '0;
    else if (push_i) entry_q <= data_i;
  end

  assign data_o = entry_q;

  // R8
  push_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> data_o == $past(data_i));
  // R11
  idle_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> $stable(data_o));
endmodule

// File: rtl/pcseq_flush.sv
module pcseq_flush (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic redirect_i,
  output logic flush_o
);
  logic flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flush_q <= 1'b0;
    else if (step_i) flush_q <= redirect_i;
  end

  assign flush_o = flush_q;

  // R9
  flush_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && step_i) |=> !flush_o);
  // R11
  flush_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(flush_o));
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          call_i,
  input  logic          jump_i,
  input  logic          ret_i,
  input  logic          low_wr_i,
  input  logic [LW-1:0] low_data_i,
  input  logic          skip_i,
  input  logic          cond_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic          flush_o
);
  src_e          src;
  logic          push, redirect;
  logic [AW-1:0] pc_q, pc_nxt, stack_val;

  pcseq_src_sel u_sel (
    .flush_i   (flush_o),
    .call_i    (call_i),
    .jump_i    (jump_i),
    .ret_i     (ret_i),
    .low_wr_i  (low_wr_i),
    .skip_i    (skip_i),
    .cond_i    (cond_i),
    .src_o     (src),
    .push_o    (push),
    .redirect_o(redirect)
  );

  pcseq_addr_mux #(.AW(AW), .LW(LW)) u_mux (
    .pc_i    (pc_q),
    .stack_i (stack_val),
    .target_i(target_i),
    .low_i   (low_data_i),
    .src_i   (src),
    .pc_o    (pc_nxt)
  );

  pcseq_ret_stack #(.AW(AW)) u_stack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(push && step_i),
    .data_i(pc_q),
    .data_o(stack_val)
  );

  pcseq_flush u_flush (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_i),
    .redirect_i(redirect),
    .flush_o   (flush_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (step_i) pc_q <= pc_nxt;
  end

  assign fetch_addr_o = pc_q;

  // R2
  always_comb reset_zero_chk: assert (rst_ni || (pc_q == '0 && !flush_o));
  // R11
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(fetch_addr_o));
  // R1
  pc_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !flush_o && !call_i && !jump_i && !ret_i && !low_wr_i && !skip_i)
    |=> (fetch_addr_o == $past(fetch_addr_o) + AW'(1)) && !flush_o);
  // R5
  jump_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !flush_o && (call_i || jump_i))
    |=> (fetch_addr_o == $past(target_i)) && flush_o);
  // R9
  flush_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && flush_o) |=> fetch_addr_o == $past(fetch_addr_o) + AW'(1));
endmodule

// File: tb/pcseq_top_tb_top.sv
module pcseq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       step, call, jump, ret, low_wr, skip, cond;
  logic [7:0] low_data;
  logic [9:0] target;
  logic [9:0] fetch_addr;
  logic       flush;

  int n_cmp = 0;
  int n_bad = 0;
  int m_pc, m_stk;
  bit m_fl, m_called;

  always #10 clk = ~clk;

  pcseq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .call_i(call), .jump_i(jump),
    .ret_i(ret), .low_wr_i(low_wr), .low_data_i(low_data), .skip_i(skip),
    .cond_i(cond), .target_i(target), .fetch_addr_o(fetch_addr), .flush_o(flush)
  );

  task automatic compare(input string tag);
    n_cmp++;
    if (fetch_addr !== m_pc[9:0]) begin
      n_bad++;
      $display("FAIL %s addr: actual %0d expected %0d", tag, fetch_addr, m_pc);
    end
    n_cmp++;
    if (flush !== m_fl) begin
      n_bad++;
      $display("FAIL %s flush: actual %0d expected %0d", tag, flush, m_fl);
    end
  endtask

  // one instruction cycle: drive, model, clock, compare
  task automatic cyc(input bit st, input bit c, input bit j, input bit r,
                     input bit lw, input bit sk, input bit cd,
                     input int tg, input int ld, input string tag);
    int npc, nstk;
    bit nfl;
    step = st; call = c; jump = j; ret = r; low_wr = lw; skip = sk; cond = cd;
    target = tg[9:0]; low_data = ld[7:0];
    npc = m_pc; nstk = m_stk; nfl = m_fl;
    if (st) begin
      nfl = 1'b0;
      if (m_fl)          npc = (m_pc + 1) % 1024;
      else if (c)        begin nstk = m_pc; npc = tg % 1024; nfl = 1; m_called = 1; end
      else if (j)        begin npc = tg % 1024; nfl = 1; end
      else if (r)        begin npc = m_stk; nfl = 1; end
      else if (lw)       begin npc = (m_pc / 256) * 256 + (ld % 256); nfl = 1; end
      else if (sk && cd) begin npc = (m_pc + 1) % 1024; nfl = 1; end
      else               npc = (m_pc + 1) % 1024;
    end
    @(posedge clk);
    @(negedge clk);
    m_pc = npc; m_stk = nstk; m_fl = nfl;
    compare(tag);
  endtask

  task automatic nop(input string tag);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step = 0; call = 0; jump = 0; ret = 0; low_wr = 0; skip = 0; cond = 0;
    target = '0; low_data = '0;
    rst_n = 1'b0;
    m_pc = 0; m_stk = 0; m_fl = 0; m_called = 0;
    repeat (3) @(negedge clk);
    compare("R2 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R2 after release");

    for (int i = 0; i < 4; i++) nop("R1 increment");
    cyc(0, 1, 1, 1, 1, 1, 1, 5, 5, "R11 idle with strobes");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 idle");
    // wrap around
    cyc(1, 0, 1, 0, 0, 0, 0, 1022, 0, "R5 jump");
    nop("R9 flush slot");
    nop("R1 wrap");
    nop("R1 wrap to zero");
    // skip taken / not taken
    cyc(1, 0, 0, 0, 0, 1, 1, 0, 0, "R3 skip taken");
    nop("R9 after skip");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, 0, "R3 skip not taken");
    // low byte write in region 2
    cyc(1, 0, 1, 0, 0, 0, 0, 600, 0, "R5 jump region 2");
    nop("R9");
    cyc(1, 0, 0, 0, 1, 0, 0, 0, 8'h3c, "R4 low write");
    nop("R9");
    cyc(1, 0, 1, 0, 0, 0, 0, 1000, 0, "R5 jump region 3");
    nop("R9");
    cyc(1, 0, 0, 0, 1, 0, 0, 0, 8'hff, "R4 low write top");
    nop("R9");
    // call / return
    cyc(1, 1, 0, 0, 0, 0, 0, 300, 0, "R6 call");
    nop("R9");
    nop("R1");
    cyc(1, 0, 0, 1, 0, 0, 0, 0, 0, "R7 return");
    nop("R9");
    // nested call overwrites
    cyc(1, 1, 0, 0, 0, 0, 0, 100, 0, "R6 call outer");
    nop("R9");
    cyc(1, 1, 0, 0, 0, 0, 0, 200, 0, "R8 call inner");
    nop("R9");
    nop("R1");
    cyc(1, 0, 0, 1, 0, 0, 0, 0, 0, "R8 return latest");
    nop("R9");
    // strobes during flush slot
    cyc(1, 0, 1, 0, 0, 0, 0, 50, 0, "R5 jump");
    cyc(1, 1, 1, 1, 1, 1, 1, 700, 9, "R9 strobes ignored");
    nop("R9 no flush");
    // priority
    cyc(1, 1, 1, 1, 1, 1, 1, 400, 7, "R10 call wins");
    nop("R9");
    cyc(1, 0, 1, 1, 1, 1, 1, 800, 7, "R10 jump wins");
    nop("R9");
    cyc(1, 0, 0, 1, 1, 1, 1, 0, 7, "R10 ret wins");
    nop("R9");
    cyc(1, 0, 0, 0, 1, 1, 1, 0, 7, "R10 low wins");
    nop("R9");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      bit st, c, j, r, lw, sk, cd;
      k = int'($urandom_range(0, 99));
      st = ($urandom_range(0, 9) != 0);
      c  = (k < 6);
      j  = (k >= 6 && k < 12);
      r  = (k >= 12 && k < 20) && m_called;
      lw = (k >= 20 && k < 26) || (k == 99);
      sk = (k >= 26 && k < 40) || (k == 98);
      cd = $urandom_range(0, 1) == 1;
      cyc(st, c, j, r, lw, sk, cd, int'($urandom_range(0, 1023)),
          int'($urandom_range(0, 255)), "R10 random mix");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule